// File: doc/BRIEF.md
# Three-Multiplier Complex Product Pipeline

This block multiplies two complex operands, each held as a pair of signed two's complement integers of parameterised width, and returns the exact complex product. It uses three real multipliers instead of the usual four. The product of the first real part with the sum of the second operand's parts is formed once and shared by both outputs. Two further products close the difference for the real and the imaginary output.

Operands enter with a valid strobe and may arrive on every cycle. Results leave a fixed three cycles later, with a matching strobe. The stages are: pre-add register, multiply register, post-add register. Every stage widens enough that no intermediate value can wrap. For N-bit inputs, the pre-adders give N+1 bits, the products give 2N+1 bits, and both outputs are 2N+2 bits. The outputs are never rounded, truncated or saturated.

Top module: `cmul3_top`

## Requirements
- R1: When `out_vld` is high, `p_re` equals a_re·b_re − a_im·b_im for the operands accepted three cycles earlier, as an exact signed two's complement value of 2N+2 bits.
- R2: When `out_vld` is high, `p_im` equals a_re·b_im + a_im·b_re for the operands accepted three cycles earlier, as an exact signed value of 2N+2 bits.
- R3: An operand pair presented with `in_vld` high at a rising edge produces `out_vld` high exactly three rising edges later.
- R4: Operands may be presented on every cycle. Each result depends only on its own operand pair, so back-to-back pairs do not disturb each other.
- R5: With all four inputs at the most negative value −2^(N−1), the block returns `p_re` = 0 and `p_im` = +2^(2N−1) with no wraparound.
- R6: Mixed extreme operands give exact results. Each part is drawn from the most negative value, the most positive value, zero or −1.
- R7: A synchronous active-high `rst` clears the valid pipeline. `out_vld` is low after any rising edge at which `rst` was high, including for operands that were in flight.
- R8: A cycle with `in_vld` low produces `out_vld` low three cycles later. Idle cycles between operands never produce a result strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_vld | input | 1 | Operand pair valid |
| a_re | input | N | Real part of the first operand, signed |
| a_im | input | N | Imaginary part of the first operand, signed |
| b_re | input | N | Real part of the second operand, signed |
| b_im | input | N | Imaginary part of the second operand, signed |
| out_vld | output | 1 | Result valid, `in_vld` delayed by three cycles |
| p_re | output | 2N+2 | Real part of the product, signed |
| p_im | output | 2N+2 | Imaginary part of the product, signed |

## Verification
Random operands with mixed signs exercise the shared product and all three pre-adders together. A mistake in any one combining term then shows up as a mismatch in only one of the two outputs. Operands built from the most negative value, the most positive value, zero and −1 reach the widest pre-adder sums. They separate a correct bit-growth chain from one that is a single bit short. Dense bursts test whether consecutive results stay independent. Sparse valid patterns and a reset issued while operands are in flight test whether the strobe follows the input by exactly three cycles.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;

    // Fixed latency: pre-add register, multiply register, post-add register
    localparam int unsigned PIPE_LAT = 3;

    // Number of real multipliers in the shared-term form
    localparam int unsigned NUM_MUL = 3;

    // Multiplier slot assignment
    typedef enum logic [1:0] {
        MUL_SHARED = 2'd0,   // a_re * (b_re + b_im)
        MUL_REAL   = 2'd1,   // (a_re + a_im) * b_im
        MUL_IMAG   = 2'd2    // (a_im - a_re) * b_re
    } mul_slot_e;

    // Width growth rules
    function automatic int unsigned pre_w(input int unsigned n);
        return n + 1;
    endfunction

    function automatic int unsigned prod_w(input int unsigned n);
        return pre_w(n) + n;
    endfunction

    function automatic int unsigned out_w(input int unsigned n);
        return prod_w(n) + 1;
    endfunction

endpackage

// File: rtl/cmul3_preadd.sv
module cmul3_preadd
    import cmul3_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  logic                          clk,
    input  logic signed [N-1:0]           a_re,
    input  logic signed [N-1:0]           a_im,
    input  logic signed [N-1:0]           b_re,
    input  logic signed [N-1:0]           b_im,
    output logic signed [pre_w(N)-1:0]    sum_b,
    output logic signed [pre_w(N)-1:0]    sum_a,
    output logic signed [pre_w(N)-1:0]    dif_a,
    output logic signed [N-1:0]           a_re_q,
    output logic signed [N-1:0]           b_re_q,
    output logic signed [N-1:0]           b_im_q
);
    localparam int unsigned PW = pre_w(N);

    logic signed [PW-1:0] are_x, aim_x, bre_x, bim_x;

    // Sign extension before every add or subtract
    always_comb begin
        are_x = PW'(a_re);
        aim_x = PW'(a_im);
        bre_x = PW'(b_re);
        bim_x = PW'(b_im);
    end

    always_ff @(posedge clk) begin
        sum_b  <= bre_x + bim_x;
        sum_a  <= are_x + aim_x;
        dif_a  <= aim_x - are_x;
        a_re_q <= a_re;
        b_re_q <= b_re;
        b_im_q <= b_im;
    end

endmodule

// File: rtl/cmul3_mul.sv
module cmul3_mul #(
    parameter int unsigned AW = 17,
    parameter int unsigned BW = 16
) (
    input  logic                    clk,
    input  logic signed [AW-1:0]    op_a,
    input  logic signed [BW-1:0]    op_b,
    output logic signed [AW+BW-1:0] prod
);
    localparam int unsigned RW = AW + BW;

    logic signed [RW-1:0] a_x, b_x;

    always_comb begin
        a_x = RW'(op_a);
        b_x = RW'(op_b);
    end

    // The product of AW and BW bit signed values always fits in AW+BW bits
    always_ff @(posedge clk) begin
        prod <= a_x * b_x;
    end

endmodule

// File: rtl/cmul3_postadd.sv
module cmul3_postadd #(
    parameter int unsigned PRW = 33
) (
    input  logic                   clk,
    input  logic signed [PRW-1:0]  p_shared,
    input  logic signed [PRW-1:0]  p_real,
    input  logic signed [PRW-1:0]  p_imag,
    output logic signed [PRW:0]    res_re,
    output logic signed [PRW:0]    res_im
);
    localparam int unsigned OW = PRW + 1;

    logic signed [OW-1:0] sh_x, re_x, im_x;

    always_comb begin
        sh_x = OW'(p_shared);
        re_x = OW'(p_real);
        im_x = OW'(p_imag);
    end

    always_ff @(posedge clk) begin
        res_re <= sh_x - re_x;
        res_im <= sh_x + im_x;
    end

endmodule

// File: rtl/cmul3_top.sv
module cmul3_top
    import cmul3_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_vld,
    input  logic signed [N-1:0]          a_re,
    input  logic signed [N-1:0]          a_im,
    input  logic signed [N-1:0]          b_re,
    input  logic signed [N-1:0]          b_im,
    output logic                         out_vld,
    output logic signed [2*N+1:0]        p_re,
    output logic signed [2*N+1:0]        p_im
);
    localparam int unsigned PW  = pre_w(N);
    localparam int unsigned PRW = prod_w(N);
    localparam int unsigned OW  = out_w(N);

    // Pre-add stage outputs carried as one record
    typedef struct packed {
        logic signed [PW-1:0] sum_b;
        logic signed [PW-1:0] sum_a;
        logic signed [PW-1:0] dif_a;
        logic signed [N-1:0]  a_re;
        logic signed [N-1:0]  b_re;
        logic signed [N-1:0]  b_im;
    } pre_stage_t;

    pre_stage_t pre_q;

    logic signed [PW-1:0]  mul_wide   [NUM_MUL];
    logic signed [N-1:0]   mul_narrow [NUM_MUL];
    logic signed [PRW-1:0] mul_prod   [NUM_MUL];

    logic signed [OW-1:0]  res_re, res_im;
    logic [PIPE_LAT-1:0]   vld_sr;

    // Stage 1: three pre-combining adders
    cmul3_preadd #(.N(N)) u_pre (
        .clk    (clk),
        .a_re   (a_re),
        .a_im   (a_im),
        .b_re   (b_re),
        .b_im   (b_im),
        .sum_b  (pre_q.sum_b),
        .sum_a  (pre_q.sum_a),
        .dif_a  (pre_q.dif_a),
        .a_re_q (pre_q.a_re),
        .b_re_q (pre_q.b_re),
        .b_im_q (pre_q.b_im)
    );

    // Operand routing to the three multipliers
    always_comb begin
        mul_wide[MUL_SHARED]   = pre_q.sum_b;
        mul_narrow[MUL_SHARED] = pre_q.a_re;
        mul_wide[MUL_REAL]     = pre_q.sum_a;
        mul_narrow[MUL_REAL]   = pre_q.b_im;
        mul_wide[MUL_IMAG]     = pre_q.dif_a;
        mul_narrow[MUL_IMAG]   = pre_q.b_re;
    end

    // Stage 2: three real multipliers
    for (genvar gi = 0; gi < NUM_MUL; gi++) begin : g_mul
        cmul3_mul #(.AW(PW), .BW(N)) u_mul (
            .clk  (clk),
            .op_a (mul_wide[gi]),
            .op_b (mul_narrow[gi]),
            .prod (mul_prod[gi])
        );
    end

    // Stage 3: final add and subtract
    cmul3_postadd #(.PRW(PRW)) u_post (
        .clk      (clk),
        .p_shared (mul_prod[MUL_SHARED]),
        .p_real   (mul_prod[MUL_REAL]),
        .p_imag   (mul_prod[MUL_IMAG]),
        .res_re   (res_re),
        .res_im   (res_im)
    );

    // Valid pipeline, the only reset state in the block
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_sr <= '0;
        end else begin
            vld_sr <= {vld_sr[PIPE_LAT-2:0], in_vld};
        end
    end

    assign out_vld = vld_sr[PIPE_LAT-1];
    assign p_re    = res_re;
    assign p_im    = res_im;

endmodule

// File: rtl/cmul3_chk.sv
module cmul3_chk #(
    parameter int unsigned N = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_vld,
    input logic signed [N-1:0]    a_re,
    input logic signed [N-1:0]    a_im,
    input logic signed [N-1:0]    b_re,
    input logic signed [N-1:0]    b_im,
    input logic                   out_vld,
    input logic signed [2*N+1:0]  p_re,
    input logic signed [2*N+1:0]  p_im
);
    localparam int unsigned OW = 2 * N + 2;
    localparam logic signed [N-1:0]  MINV = {1'b1, {(N-1){1'b0}}};
    localparam logic signed [OW-1:0] CORNER_IM = OW'(1) <<< (2 * N - 1);

    logic signed [OW-1:0] ref_re, ref_im;
    logic                 all_min;

    // Direct four-multiplier reference
    always_comb begin
        ref_re  = OW'(a_re) * OW'(b_re) - OW'(a_im) * OW'(b_im);
        ref_im  = OW'(a_re) * OW'(b_im) + OW'(a_im) * OW'(b_re);
        all_min = (a_re == MINV) && (a_im == MINV) && (b_re == MINV) && (b_im == MINV);
    end

    AST_RE_EXACT: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (p_re == $past(ref_re, 3))); // R1

    AST_IM_EXACT: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (p_im == $past(ref_im, 3))); // R2

    AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_vld |-> ##3 out_vld); // R3

    AST_CORNER_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (in_vld && all_min) |-> ##3 (p_re == '0 && p_im == CORNER_IM)); // R5

    AST_RST_CLEARS: assert property (@(posedge clk)
        rst |=> !out_vld); // R7

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !in_vld |-> ##3 !out_vld); // R8

endmodule

bind cmul3_top cmul3_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .a_re    (a_re),
    .a_im    (a_im),
    .b_re    (b_re),
    .b_im    (b_im),
    .out_vld (out_vld),
    .p_re    (p_re),
    .p_im    (p_im)
);

// File: tb/cmul3_top_tb.sv
module cmul3_top_tb;
    localparam int unsigned N  = 16;
    localparam int unsigned OW = 2 * N + 2;
    localparam longint MINV = -(longint'(1) <<< (N - 1));
    localparam longint MAXV = (longint'(1) <<< (N - 1)) - 1;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_vld = 1'b0;
    logic signed [N-1:0]   a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic                  out_vld;
    logic signed [OW-1:0]  p_re, p_im;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string cur_tag = "R1";

    // Expected-value history, three deep
    logic                 e_vld [3];
    logic signed [OW-1:0] e_re  [3];
    logic signed [OW-1:0] e_im  [3];
    string                e_tag [3];

    always #2 clk = ~clk;   // 250 MHz

    cmul3_top #(.N(N)) u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .out_vld(out_vld), .p_re(p_re), .p_im(p_im)
    );

    function automatic logic signed [OW-1:0] mul_re(longint ar, longint ai, longint br, longint bi);
        longint r = ar * br - ai * bi;
        return OW'(r);
    endfunction

    function automatic logic signed [OW-1:0] mul_im(longint ar, longint ai, longint br, longint bi);
        longint r = ar * bi + ai * br;
        return OW'(r);
    endfunction

    function automatic longint pick_edge(int sel);
        case (sel % 4)
            0: return MINV;
            1: return MAXV;
            2: return 0;
            default: return -1;
        endcase
    endfunction

    task automatic check(string req, logic signed [OW-1:0] act, logic signed [OW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bench model of the three-cycle requirement (R3, R7)
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) e_vld[i] <= 1'b0;
        end else begin
            e_vld[0] <= in_vld;
            e_vld[1] <= e_vld[0];
            e_vld[2] <= e_vld[1];
        end
        e_re[0]  <= mul_re(a_re, a_im, b_re, b_im);
        e_im[0]  <= mul_im(a_re, a_im, b_re, b_im);
        e_tag[0] <= cur_tag;
        for (int i = 1; i < 3; i++) begin
            e_re[i]  <= e_re[i-1];
            e_im[i]  <= e_im[i-1];
            e_tag[i] <= e_tag[i-1];
        end
    end

    // Continuous comparison away from the active edge
    bit run_chk = 0;
    always @(negedge clk) begin
        if (run_chk && !rst) begin
            check(e_vld[2] ? "R3 strobe" : "R8 strobe", OW'(out_vld), OW'(e_vld[2]));
            if (e_vld[2]) begin
                check({e_tag[2], "/R1 real"}, p_re, e_re[2]);
                check({e_tag[2], "/R2 imag"}, p_im, e_im[2]);
            end
        end
    end

    task automatic drive(bit v, longint ar, longint ai, longint br, longint bi, string tag);
        @(negedge clk);
        in_vld  = v;
        a_re    = N'(ar);
        a_im    = N'(ai);
        b_re    = N'(br);
        b_im    = N'(bi);
        cur_tag = tag;
    endtask

    task automatic drive_rand(bit v, string tag);
        drive(v, longint'($signed(N'($urandom))), longint'($signed(N'($urandom))),
              longint'($signed(N'($urandom))), longint'($signed(N'($urandom))), tag);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 3; i++) begin
            e_vld[i] = 1'b0; e_re[i] = '0; e_im[i] = '0; e_tag[i] = "R1";
        end
        repeat (4) @(negedge clk);
        // R7: reset state
        check("R7 reset state", OW'(out_vld), OW'(0));
        #1 rst = 1'b0;
        run_chk = 1;

        // R5: all inputs most negative, explicit check
        drive(1, MINV, MINV, MINV, MINV, "R5");
        drive(0, 0, 0, 0, 0, "R8");
        drive(0, 0, 0, 0, 0, "R8");
        @(negedge clk);
        check("R5 real corner", p_re, '0);
        check("R5 imag corner", p_im, OW'(1) <<< (2 * N - 1));

        // R6: all combinations of edge values
        for (int k = 0; k < 256; k++)
            drive(1, pick_edge(k), pick_edge(k / 4), pick_edge(k / 16), pick_edge(k / 64), "R6");

        // R4: back-to-back random burst
        for (int k = 0; k < 400; k++) drive_rand(1, "R4");

        // R8: sparse valid with random gaps
        for (int k = 0; k < 600; k++) drive_rand(($urandom % 3) == 0, "R8");

        // R7: reset while operands are in flight
        drive_rand(1, "R7");
        drive_rand(1, "R7");
        @(negedge clk);
        rst = 1'b1; in_vld = 1'b0;
        @(negedge clk);
        check("R7 in-flight cleared", OW'(out_vld), OW'(0));
        @(negedge clk);
        check("R7 in-flight cleared", OW'(out_vld), OW'(0));
        #1 rst = 1'b0;

        // R1/R2: mixed random with edge values after reset
        for (int k = 0; k < 300; k++) begin
            if (($urandom % 4) == 0)
                drive(1, pick_edge($urandom), pick_edge($urandom), pick_edge($urandom), pick_edge($urandom), "R6");
            else
                drive_rand(1, "R1");
        end
        repeat (5) drive(0, 0, 0, 0, 0, "R8");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("[TB] FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule